// File: doc/BRIEF.md
# Compacting Tag-Wakeup Scheduling Queue

This block is the issue window of an out-of-order core. Each cycle it pulls renamed instructions from the head of an in-order dispatch FIFO into its empty rows. Each row holds a unit kind, a destination tag, a destination register and two source tags. A source tag of zero means that operand is ready. Tags broadcast on the result buses clear the matching source tags. Rows whose operands are all ready are granted, oldest first, to idle functional units of their kind.

A row stays in the queue after it fires. When its own tag and register appear on a result bus, the row is marked complete. It is removed at the next edge. Removal shifts the younger rows up, so row index always follows instruction age.

The dispatch FIFO presents its oldest entries as a window: entry 0 is the head, and the FIFO reports how many entries are valid. The block answers with how many it took this cycle. Functional unit idle flags and the result buses come from the execution side. The grant vector, with the tag and register of each granted instruction, goes back to it in the same cycle.

Top module: `sched_queue`

## Requirements
- R1: The queue has 2*(K0+K1+K2) rows. After reset it is empty and issues no grants. With every functional unit busy, it accepts exactly that many instructions in total, however many are offered.
- R2: Each cycle it accepts min(free rows, dispCount) window entries, taking entry 0 first and placing them below the rows already held, in window order. Free rows are counted from the state at the start of the cycle.
- R3: A source tag of 0 marks the operand as available, and any nonzero tag marks it as waiting. Tag 0 is never allocated to an instruction.
- R4: A row fires only if it is held, has not fired yet, has both source tags at zero, and an idle unit of its kind exists. A fired row stays in the queue but never fires again. Grants go only to idle units, and each unit receives at most one row.
- R5: Rows are considered oldest first, and each takes the lowest-index idle unit of its kind. Units 0..K0-1 are kind 0, the next K1 units are kind 1, and the last K2 units are kind 2. The grant, tag and register appear in the same cycle as the request.
- R6: A valid bus tag clears every equal source tag in the held rows, including rows loaded in that same cycle. A row woken this way can fire in the next cycle.
- R7: A held row whose destination tag and register both equal a valid bus broadcast is marked complete at that edge and removed at the following edge. Its slot is offered to dispatch in the cycle after removal.
- R8: Removal compacts the queue. Surviving rows keep their relative order with no gaps, and several removals in one cycle behave as if they were done one at a time.
- R9: fireCount equals the number of grants issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispCount | input | CW | Valid entries in the dispatch window |
| dispKind | input | ROWS x 2 | Unit kind of each window entry |
| dispTag | input | ROWS x 16 | Destination tag of each window entry |
| dispReg | input | ROWS x 7 | Destination register of each window entry |
| dispSrc1 | input | ROWS x 16 | First source tag (0 = ready) |
| dispSrc2 | input | ROWS x 16 | Second source tag (0 = ready) |
| dispTaken | output | CW | Window entries accepted this cycle |
| fuIdle | input | NFU | Idle flag per functional unit |
| fuGrant | output | NFU | Grant per functional unit |
| fuTag | output | NFU x 16 | Tag of the granted instruction |
| fuReg | output | NFU x 7 | Destination register of the granted instruction |
| busValid | input | NBUS | Result bus valid |
| busTag | input | NBUS x 16 | Result bus tag |
| busReg | input | NBUS x 7 | Result bus register |
| fireCount | output | FCW | Number of grants this cycle |

## Verification
The hardest situations to reach are two. The first is a consumer that enters the queue in the very cycle its producer broadcasts. The second is two or more completions landing together, so that compaction removes non-adjacent rows in one step. The bench keeps its dispatch FIFO partly full and uses short random unit latencies over two result buses. Dependencies are drawn from a small register pool, which makes both situations recur. It counts how often each occurs and requires both to have happened.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int TAG_W  = 16;
  localparam int REG_W  = 7;
  localparam int KIND_W = 2;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [KIND_W-1:0] kind_t;

  typedef struct packed {
    logic  valid;
    logic  fired;
    logic  done;
    kind_t kind;
    reg_t  dstReg;
    tag_t  dstTag;
    tag_t  src1;
    tag_t  src2;
  } entry_t;

  typedef struct packed {
    logic valid;
    logic fired;
    logic done;
    logic ready;
    kind_t kind;
  } rowStat_t;

  typedef struct packed {
    logic fire;
    logic load;
  } rowCtl_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int K0     = 2,
  parameter int K1     = 1,
  parameter int K2     = 1,
  parameter int ROWS   = 8,
  parameter int CW     = 4,
  parameter int FCW    = 3,
  parameter int RIDX_W = 3,
  localparam int NFU   = K0 + K1 + K2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rowStat_t                     stat [ROWS],
  input  logic [CW-1:0]                occ,
  input  logic [CW-1:0]                dispCount,
  input  logic [NFU-1:0]               fuIdle,
  output rowCtl_t                      ctl [ROWS],
  output logic [NFU-1:0]               fuGrant,
  output logic [NFU-1:0][RIDX_W-1:0]   grantRow,
  output logic [CW-1:0]                dispTaken,
  output logic [FCW-1:0]               fireCount
);

  function automatic kind_t unitKind(int f);
    if (f < K0) return kind_t'(0);
    if (f < K0 + K1) return kind_t'(1);
    return kind_t'(2);
  endfunction

  logic [NFU-1:0] avail;
  logic           placed;
  logic [CW-1:0]  freeRows;
  logic [CW-1:0]  takeNow;

  always_comb begin
    avail    = fuIdle;
    fuGrant  = '0;
    grantRow = '0;
    placed   = 1'b0;
    freeRows = CW'(ROWS) - occ;
    takeNow  = (dispCount < freeRows) ? dispCount : freeRows;
    for (int r = 0; r < ROWS; r++) begin
      ctl[r].fire = 1'b0;
      ctl[r].load = (int'(occ) <= r) && (r < int'(occ) + int'(takeNow));
      placed = 1'b0;
      if (stat[r].valid && !stat[r].fired && stat[r].ready) begin
        for (int f = 0; f < NFU; f++) begin
          if (!placed && avail[f] && unitKind(f) == stat[r].kind) begin
            avail[f]    = 1'b0;
            fuGrant[f]  = 1'b1;
            grantRow[f] = RIDX_W'(r);
            ctl[r].fire = 1'b1;
            placed      = 1'b1;
          end
        end
      end
    end
  end

  assign dispTaken = takeNow;

  always_comb begin
    fireCount = '0;
    for (int f = 0; f < NFU; f++) fireCount = fireCount + FCW'(fuGrant[f]);
  end

  // R4: a busy unit is never granted
  assert_idle_fu_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fuGrant & ~fuIdle) == '0);

  // R2: accepted entries never exceed the offer nor the free rows
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dispTaken <= dispCount) && (int'(occ) + int'(dispTaken) <= ROWS));

endmodule

// File: rtl/sq_rows.sv
module sq_rows
  import sq_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int NBUS   = 2,
  parameter int CW     = 4,
  parameter int RIDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rowCtl_t                      ctl [ROWS],
  input  logic [ROWS-1:0][KIND_W-1:0]  dispKind,
  input  logic [ROWS-1:0][TAG_W-1:0]   dispTag,
  input  logic [ROWS-1:0][REG_W-1:0]   dispReg,
  input  logic [ROWS-1:0][TAG_W-1:0]   dispSrc1,
  input  logic [ROWS-1:0][TAG_W-1:0]   dispSrc2,
  input  logic [NBUS-1:0]              busValid,
  input  logic [NBUS-1:0][TAG_W-1:0]   busTag,
  input  logic [NBUS-1:0][REG_W-1:0]   busReg,
  output rowStat_t                     stat [ROWS],
  output logic [CW-1:0]                occ,
  output logic [ROWS-1:0][TAG_W-1:0]   rowTag,
  output logic [ROWS-1:0][REG_W-1:0]   rowReg
);

  entry_t        q      [ROWS];
  entry_t        stageA [ROWS];
  entry_t        nxt    [ROWS];
  logic [ROWS-1:0] keep;
  logic [RIDX_W-1:0] wIdx;
  int            pos;
  int            nLoad;
  int            nDone;

  function automatic logic tagOnBus(tag_t t);
    logic hit = 1'b0;
    for (int b = 0; b < NBUS; b++)
      if (busValid[b] && t != '0 && busTag[b] == t) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic ownOnBus(tag_t t, reg_t g);
    logic hit = 1'b0;
    for (int b = 0; b < NBUS; b++)
      if (busValid[b] && t != '0 && busTag[b] == t && busReg[b] == g) hit = 1'b1;
    return hit;
  endfunction

  // row status towards control
  always_comb begin
    occ = '0;
    for (int r = 0; r < ROWS; r++) begin
      stat[r].valid = q[r].valid;
      stat[r].fired = q[r].fired;
      stat[r].done  = q[r].done;
      stat[r].ready = (q[r].src1 == '0) && (q[r].src2 == '0);
      stat[r].kind  = q[r].kind;
      rowTag[r]     = q[r].dstTag;
      rowReg[r]     = q[r].dstReg;
      occ           = occ + CW'(q[r].valid);
    end
  end

  // fire mark, load, wakeup, compaction, completion
  always_comb begin
    wIdx = '0;
    for (int r = 0; r < ROWS; r++) begin
      stageA[r] = q[r];
      wIdx = '0;
      if (ctl[r].fire) stageA[r].fired = 1'b1;
      if (ctl[r].load) begin
        wIdx             = RIDX_W'(r - int'(occ));
        stageA[r].valid  = 1'b1;
        stageA[r].fired  = 1'b0;
        stageA[r].done   = 1'b0;
        stageA[r].kind   = dispKind[wIdx];
        stageA[r].dstTag = dispTag[wIdx];
        stageA[r].dstReg = dispReg[wIdx];
        stageA[r].src1   = dispSrc1[wIdx];
        stageA[r].src2   = dispSrc2[wIdx];
      end
      if (stageA[r].valid && tagOnBus(stageA[r].src1)) stageA[r].src1 = '0;
      if (stageA[r].valid && tagOnBus(stageA[r].src2)) stageA[r].src2 = '0;
      keep[r] = stageA[r].valid && !q[r].done;
    end
    pos = 0;
    for (int i = 0; i < ROWS; i++) nxt[i] = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (keep[r]) begin
        nxt[RIDX_W'(pos)] = stageA[r];
        pos = pos + 1;
      end
    end
    for (int i = 0; i < ROWS; i++)
      if (nxt[i].valid && ownOnBus(nxt[i].dstTag, nxt[i].dstReg)) nxt[i].done = 1'b1;
  end

  always_comb begin
    nLoad = 0;
    nDone = 0;
    for (int r = 0; r < ROWS; r++) begin
      nLoad = nLoad + int'(ctl[r].load);
      nDone = nDone + int'(q[r].valid && q[r].done);
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (!rstN) q[r] <= '0;
      else       q[r] <= nxt[r];
    end
  end

  // R7: occupancy follows loads and removals of completed rows
  assert_occ_track_R7: assert property (@(posedge clk) disable iff (!rstN)
    (nLoad != 0 || nDone != 0) |=> int'(occ) == $past(int'(occ)) + $past(nLoad) - $past(nDone));

  for (genvar r = 0; r < ROWS; r++) begin : g_rowChk
    // R7: a completed row must have fired earlier
    assert_done_fired_R7: assert property (@(posedge clk) disable iff (!rstN)
      (q[r].valid && q[r].done) |-> q[r].fired);
    if (r > 0) begin : g_contig
      // R8: held rows form an unbroken block from the top
      assert_contig_R8: assert property (@(posedge clk) disable iff (!rstN)
        q[r].valid |-> q[r-1].valid);
    end
  end

endmodule

// File: rtl/sched_queue.sv
module sched_queue
  import sq_pkg::*;
#(
  parameter int K0    = 2,
  parameter int K1    = 1,
  parameter int K2    = 1,
  parameter int NBUS  = 2,
  localparam int NFU  = K0 + K1 + K2,
  localparam int ROWS = 2 * NFU,
  localparam int CW   = $clog2(ROWS + 1),
  localparam int FCW  = $clog2(NFU + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CW-1:0]               dispCount,
  input  logic [ROWS-1:0][KIND_W-1:0] dispKind,
  input  logic [ROWS-1:0][TAG_W-1:0]  dispTag,
  input  logic [ROWS-1:0][REG_W-1:0]  dispReg,
  input  logic [ROWS-1:0][TAG_W-1:0]  dispSrc1,
  input  logic [ROWS-1:0][TAG_W-1:0]  dispSrc2,
  output logic [CW-1:0]               dispTaken,
  input  logic [NFU-1:0]              fuIdle,
  output logic [NFU-1:0]              fuGrant,
  output logic [NFU-1:0][TAG_W-1:0]   fuTag,
  output logic [NFU-1:0][REG_W-1:0]   fuReg,
  input  logic [NBUS-1:0]             busValid,
  input  logic [NBUS-1:0][TAG_W-1:0]  busTag,
  input  logic [NBUS-1:0][REG_W-1:0]  busReg,
  output logic [FCW-1:0]              fireCount
);

  localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  rowStat_t                   stat [ROWS];
  rowCtl_t                    ctl  [ROWS];
  logic [CW-1:0]              occ;
  logic [ROWS-1:0][TAG_W-1:0] rowTag;
  logic [ROWS-1:0][REG_W-1:0] rowReg;
  logic [NFU-1:0][RIDX_W-1:0] grantRow;

  sq_ctrl #(
    .K0(K0), .K1(K1), .K2(K2), .ROWS(ROWS), .CW(CW), .FCW(FCW), .RIDX_W(RIDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .occ(occ), .dispCount(dispCount),
    .fuIdle(fuIdle), .ctl(ctl), .fuGrant(fuGrant), .grantRow(grantRow),
    .dispTaken(dispTaken), .fireCount(fireCount)
  );

  sq_rows #(
    .ROWS(ROWS), .NBUS(NBUS), .CW(CW), .RIDX_W(RIDX_W)
  ) u_rows (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .dispKind(dispKind), .dispTag(dispTag), .dispReg(dispReg),
    .dispSrc1(dispSrc1), .dispSrc2(dispSrc2),
    .busValid(busValid), .busTag(busTag), .busReg(busReg),
    .stat(stat), .occ(occ), .rowTag(rowTag), .rowReg(rowReg)
  );

  always_comb begin
    for (int f = 0; f < NFU; f++) begin
      fuTag[f] = fuGrant[f] ? rowTag[grantRow[f]] : '0;
      fuReg[f] = fuGrant[f] ? rowReg[grantRow[f]] : '0;
    end
  end

  // R9: the reported count matches the grant vector
  assert_fire_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    int'(fireCount) == $countones(fuGrant));

  for (genvar f = 0; f < NFU; f++) begin : g_uniqA
    for (genvar g = f + 1; g < NFU; g++) begin : g_uniqB
      // R4: one row never takes two units
      assert_one_unit_R4: assert property (@(posedge clk) disable iff (!rstN)
        (fuGrant[f] && fuGrant[g]) |-> grantRow[f] != grantRow[g]);
    end
  end

endmodule

// File: tb/sched_queue_test.sv
module sched_queue_test;
  import sq_pkg::*;

  localparam int K0   = 2;
  localparam int K1   = 1;
  localparam int K2   = 1;
  localparam int NBUS = 2;
  localparam int NFU  = K0 + K1 + K2;
  localparam int ROWS = 2 * NFU;
  localparam int CW   = $clog2(ROWS + 1);
  localparam int FCW  = $clog2(NFU + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [CW-1:0]               dispCount;
  logic [ROWS-1:0][KIND_W-1:0] dispKind;
  logic [ROWS-1:0][TAG_W-1:0]  dispTag;
  logic [ROWS-1:0][REG_W-1:0]  dispReg;
  logic [ROWS-1:0][TAG_W-1:0]  dispSrc1;
  logic [ROWS-1:0][TAG_W-1:0]  dispSrc2;
  logic [CW-1:0]               dispTaken;
  logic [NFU-1:0]              fuIdle;
  logic [NFU-1:0]              fuGrant;
  logic [NFU-1:0][TAG_W-1:0]   fuTag;
  logic [NFU-1:0][REG_W-1:0]   fuReg;
  logic [NBUS-1:0]             busValid;
  logic [NBUS-1:0][TAG_W-1:0]  busTag;
  logic [NBUS-1:0][REG_W-1:0]  busReg;
  logic [FCW-1:0]              fireCount;

  sched_queue #(.K0(K0), .K1(K1), .K2(K2), .NBUS(NBUS)) uut (
    .clk(clk), .rstN(rstN), .dispCount(dispCount), .dispKind(dispKind),
    .dispTag(dispTag), .dispReg(dispReg), .dispSrc1(dispSrc1), .dispSrc2(dispSrc2),
    .dispTaken(dispTaken), .fuIdle(fuIdle), .fuGrant(fuGrant), .fuTag(fuTag),
    .fuReg(fuReg), .busValid(busValid), .busTag(busTag), .busReg(busReg),
    .fireCount(fireCount)
  );

  typedef struct {
    int kind; int tag; int rg; int s1; int s2; bit fired; bit done;
  } mEnt_t;

  mEnt_t mq[$];
  mEnt_t fifo[$];
  bit    seen[int];
  int    regOwner[16];
  int    nextTag = 1;
  bit    stall = 1'b0;
  bit    fuBusy[NFU];
  int    fuLeft[NFU];
  int    fuT[NFU];
  int    fuR[NFU];
  bit [NFU-1:0] expGrant;
  int    expTag[NFU];
  int    expReg[NFU];
  int    checks = 0;
  int    fails = 0;
  int    sameWake = 0;
  int    multiDel = 0;
  int    sumTaken = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int kindOf(int f);
    if (f < K0) return 0;
    if (f < K0 + K1) return 1;
    return 2;
  endfunction

  function automatic void newInstr();
    mEnt_t e;
    e.kind = $urandom_range(0, 2);
    e.tag  = nextTag;
    nextTag++;
    e.rg   = $urandom_range(0, 15);
    e.s1   = regOwner[$urandom_range(0, 15)];
    e.s2   = regOwner[$urandom_range(0, 15)];
    e.fired = 0;
    e.done  = 0;
    regOwner[e.rg] = e.tag;
    fifo.push_back(e);
  endfunction

  // behavioural reference: one cycle of the queue
  function automatic int modelStep();
    bit [NFU-1:0] avail = fuIdle;
    int oldSize = mq.size();
    int take;
    int nd = 0;
    mEnt_t kept[$];
    expGrant = '0;
    for (int i = 0; i < mq.size(); i++) begin
      bit got = 0;
      if (!mq[i].fired && mq[i].s1 == 0 && mq[i].s2 == 0) begin
        for (int f = 0; f < NFU; f++) begin
          if (!got && avail[f] && kindOf(f) == mq[i].kind) begin
            avail[f] = 0; expGrant[f] = 1; expTag[f] = mq[i].tag; expReg[f] = mq[i].rg;
            mq[i].fired = 1; got = 1;
          end
        end
      end
    end
    take = ROWS - mq.size();
    if (int'(dispCount) < take) take = int'(dispCount);
    for (int k = 0; k < take; k++) mq.push_back(fifo[k]);
    for (int i = 0; i < mq.size(); i++) begin
      for (int b = 0; b < NBUS; b++) begin
        if (busValid[b]) begin
          if (mq[i].s1 != 0 && mq[i].s1 == int'(busTag[b])) begin
            mq[i].s1 = 0; if (i >= oldSize) sameWake++;
          end
          if (mq[i].s2 != 0 && mq[i].s2 == int'(busTag[b])) begin
            mq[i].s2 = 0; if (i >= oldSize) sameWake++;
          end
        end
      end
    end
    foreach (mq[i]) begin
      if (mq[i].done) nd++;
      else kept.push_back(mq[i]);
    end
    if (nd >= 2) multiDel++;
    mq = kept;
    foreach (mq[i])
      for (int b = 0; b < NBUS; b++)
        if (busValid[b] && mq[i].tag == int'(busTag[b]) && mq[i].rg == int'(busReg[b]))
          mq[i].done = 1;
    return take;
  endfunction

  task automatic step(bit gen);
    int nb = 0;
    int bf[NBUS];
    int take;
    @(negedge clk);
    if (gen) repeat ($urandom_range(0, 3)) if (fifo.size() < 24) newInstr();
    foreach (fifo[i]) begin
      if (fifo[i].s1 != 0 && seen.exists(fifo[i].s1)) fifo[i].s1 = 0;
      if (fifo[i].s2 != 0 && seen.exists(fifo[i].s2)) fifo[i].s2 = 0;
    end
    dispCount = CW'((fifo.size() < ROWS) ? fifo.size() : ROWS);
    for (int i = 0; i < ROWS; i++) begin
      if (i < fifo.size()) begin
        dispKind[i] = KIND_W'(fifo[i].kind); dispTag[i] = TAG_W'(fifo[i].tag);
        dispReg[i] = REG_W'(fifo[i].rg); dispSrc1[i] = TAG_W'(fifo[i].s1);
        dispSrc2[i] = TAG_W'(fifo[i].s2);
      end else begin
        dispKind[i] = '0; dispTag[i] = '0; dispReg[i] = '0; dispSrc1[i] = '0; dispSrc2[i] = '0;
      end
    end
    for (int f = 0; f < NFU; f++) fuIdle[f] = !stall && !fuBusy[f];
    busValid = '0; busTag = '0; busReg = '0;
    for (int f = 0; f < NFU; f++) begin
      if (fuBusy[f] && fuLeft[f] == 0 && nb < NBUS) begin
        busValid[nb] = 1'b1; busTag[nb] = TAG_W'(fuT[f]); busReg[nb] = REG_W'(fuR[f]);
        bf[nb] = f; nb++;
      end
    end
    #2;
    take = modelStep();
    // R3 R4 R5: readiness, single fire, oldest-first lowest-unit grant
    check("R3 R4 R5", "grant vector", fuGrant, expGrant);
    for (int f = 0; f < NFU; f++) begin
      if (expGrant[f]) begin
        check("R5", "granted tag", fuTag[f], expTag[f]);
        check("R5", "granted reg", fuReg[f], expReg[f]);
      end
    end
    check("R9", "fire count", fireCount, $countones(expGrant));
    check("R2 R7 R8", "dispatch accepted", dispTaken, take);
    sumTaken += int'(dispTaken);
    @(posedge clk);
    #1;
    for (int b = 0; b < nb; b++) begin
      fuBusy[bf[b]] = 0;
      seen[fuT[bf[b]]] = 1;
      if (regOwner[fuR[bf[b]]] == fuT[bf[b]]) regOwner[fuR[bf[b]]] = 0;
    end
    for (int f = 0; f < NFU; f++) if (fuBusy[f] && fuLeft[f] > 0) fuLeft[f]--;
    for (int f = 0; f < NFU; f++) begin
      if (expGrant[f]) begin
        fuBusy[f] = 1; fuLeft[f] = $urandom_range(0, 3); fuT[f] = expTag[f]; fuR[f] = expReg[f];
      end
    end
    repeat (take) void'(fifo.pop_front());
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    dispCount = '0; dispKind = '0; dispTag = '0; dispReg = '0; dispSrc1 = '0; dispSrc2 = '0;
    fuIdle = '1; busValid = '0; busTag = '0; busReg = '0;
    for (int f = 0; f < NFU; f++) begin fuBusy[f] = 0; fuLeft[f] = 0; fuT[f] = 0; fuR[f] = 0; end
    for (int g = 0; g < 16; g++) regOwner[g] = 0;
    repeat (3) @(negedge clk);
    #2;
    // R1: empty after reset
    check("R1", "reset grants", fuGrant, 0);
    check("R1", "reset fire count", fireCount, 0);
    check("R1", "reset accepted", dispTaken, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: with units held busy the queue absorbs exactly its row count
    stall = 1'b1;
    repeat (20) newInstr();
    sumTaken = 0;
    repeat (6) step(1'b0);
    check("R1", "rows filled under stall", sumTaken, 2 * (K0 + K1 + K2));
    stall = 1'b0;
    repeat (2500) step(1'b1);
    repeat (400) step(1'b0);
    check("R6", "same-cycle wakeup reached", sameWake > 0, 1);
    check("R8", "multi-row removal reached", multiDel > 0, 1);
    check("R7", "queue drained", mq.size(), 0);
    check("R2", "fifo drained", fifo.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule